// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the software-visible register file of a 32-line vectored interrupt controller. It holds one configuration word per interrupt line, an enable mask, a software request mask, a global configuration word and a vector table base. Software reaches all of them through a simple 32-bit word-indexed read/write port. The enable and software masks can be loaded whole, or changed one bit at a time through companion set and clear aliases.

Each hardware interrupt line is brought into the clock domain through a two-flop synchronizer and then captured into a raw level register. The bank forms the pending vector, which is the OR of the hardware and software requests gated by the enable mask. It presents the configuration words, the masks and the pending vector to a separate priority resolver. The resolver returns a status word and a computed vector address, and the bank makes both readable. A write to an index that holds no writable register raises a one-cycle error strobe.

The bus index is the byte offset divided by four. The enclosing fabric drops the two low address bits before they reach the port.

Top module: `irqbank_regs`

## Requirements
- R1: After a synchronous active-high reset, every stored register is zero. This covers all 32 line configuration words, the enable mask, the software mask, the raw levels, the global configuration and the vector base. Every output except the read data follows from these, and reads of all of them return zero.
- R2: The word index map is fixed. Indices 0..31 are the line configuration words. Index 32 loads the enable mask, 33 sets enable bits and 34 clears them. Index 35 reads pending and 36 reads the raw levels. Index 37 loads the software mask, 38 sets its bits and 39 clears them. Index 40 is the global configuration, 41 the resolver status, 42 the vector base and 43 the resolver vector address. Indices 44..63 are unmapped.
- R3: Each line configuration word stores all 32 written bits. Reads return the stored value, and word k appears on bits [32k+31:32k] of the configuration output.
- R4: A write to index 32 replaces the enable mask. A write to 33 ORs the data into it. A write to 34 ANDs it with the inverted data.
- R5: A write to index 37 replaces the software mask. A write to 38 ORs the data into it. A write to 39 ANDs it with the inverted data.
- R6: Raw bit i follows input line i through two synchronizer flops and a capture register. A change that is driven before clock edge n is visible after edge n+2 and not after edge n+1.
- R7: The pending vector equals (raw OR software mask) AND enable mask. It is driven on its output and returned by a read of index 35.
- R8: Reads of index 41 and index 43 return the resolver's status and vector address inputs, as they were on the read cycle.
- R9: The global configuration word (index 40) and the vector base (index 42) store all 32 written bits and are driven on their outputs.
- R10: Read data is registered and appears the cycle after the read strobe. It holds until the next read. Reads of the alias indices 33, 34, 38 and 39 and of indices 44..63 return zero.
- R11: Writes to indices 35, 36, 41 and 43 change no stored register.
- R12: The write error strobe is high for exactly one cycle, the cycle after a write to index 35, 36, 41, 43 or 44..63. It stays low after a write to any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous interrupt request levels |
| bus_idx | input | 6 | Word index (byte offset divided by four) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| wr_err | output | 1 | One-cycle pulse after a write to a non-writable index |
| rsv_status_i | input | 32 | Status word from the priority resolver |
| rsv_vaddr_i | input | 32 | Vector address from the priority resolver |
| line_cfg_o | output | 1024 | All line configuration words, line k in bits [32k+31:32k] |
| enable_o | output | 32 | Enable mask |
| pending_o | output | 32 | Pending vector |
| gcfg_o | output | 32 | Global configuration word |
| vbase_o | output | 32 | Vector table base |

## Verification
The whole 64-entry index space is swept twice: once for reads straight after reset, and once with a distinct pattern written to every index. The second sweep separates writable indices from read-only, alias and unmapped ones, both through the error strobe and through a full readback against a model. A long run of mixed load, set and clear operations on both masks, driven by pseudo-random data, tells apart OR, AND-NOT and replace behaviour. The pending output is then tried with masks that isolate the hardware path, the software path and enable gating. Single-cycle steps on the interrupt inputs pin down the synchronizer latency to the exact edge.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    localparam int LINES   = 32;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = 6;
    localparam int LINE_IW = $clog2(LINES);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Word index map (software-visible offsets)
    localparam idx_t IX_ENA      = idx_t'(32);
    localparam idx_t IX_ENA_SET  = idx_t'(33);
    localparam idx_t IX_ENA_CLR  = idx_t'(34);
    localparam idx_t IX_PEND     = idx_t'(35);
    localparam idx_t IX_RAW      = idx_t'(36);
    localparam idx_t IX_SOFT     = idx_t'(37);
    localparam idx_t IX_SOFT_SET = idx_t'(38);
    localparam idx_t IX_SOFT_CLR = idx_t'(39);
    localparam idx_t IX_GCFG     = idx_t'(40);
    localparam idx_t IX_STAT     = idx_t'(41);
    localparam idx_t IX_VBASE    = idx_t'(42);
    localparam idx_t IX_VADDR    = idx_t'(43);

    typedef enum logic [1:0] {
        MOP_NONE,
        MOP_LOAD,
        MOP_SET,
        MOP_CLR
    } mask_op_e;

    typedef struct packed {
        mask_op_e op;
        word_t    data;
    } mask_cmd_t;

    function automatic logic idx_is_line(idx_t ix);
        return ix < idx_t'(LINES);
    endfunction

    function automatic logic idx_writable(idx_t ix);
        logic w;
        w = idx_is_line(ix);
        case (ix)
            IX_ENA, IX_ENA_SET, IX_ENA_CLR,
            IX_SOFT, IX_SOFT_SET, IX_SOFT_CLR,
            IX_GCFG, IX_VBASE: w = 1'b1;
            default: ;
        endcase
        return w;
    endfunction

    function automatic mask_cmd_t mask_decode(logic wr, idx_t ix, idx_t ld, idx_t st,
                                              idx_t cl, word_t d);
        mask_cmd_t c;
        c.data = d;
        c.op   = MOP_NONE;
        if (wr) begin
            if (ix == ld)      c.op = MOP_LOAD;
            else if (ix == st) c.op = MOP_SET;
            else if (ix == cl) c.op = MOP_CLR;
        end
        return c;
    endfunction

    function automatic word_t mask_apply(mask_op_e op, word_t cur, word_t d);
        word_t n;
        case (op)
            MOP_LOAD: n = d;
            MOP_SET:  n = cur | d;
            MOP_CLR:  n = cur & ~d;
            default:  n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/irqbank_sync.sv
module irqbank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irqbank_mask.sv
module irqbank_mask
    import irqbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mask_cmd_t cmd,
    output word_t     mask
);
    word_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_apply(cmd.op, mask_q, cmd.data);
    end

    assign mask = mask_q;

    // R1
    mask_rst_chk: assert property (@(posedge clk) rst |=> mask_q == '0);
    // R4 R5
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.op == MOP_LOAD |=> mask_q == $past(cmd.data));
    // R4 R5
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.op == MOP_SET |=> (mask_q & $past(cmd.data)) == $past(cmd.data));
    // R4 R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.op == MOP_CLR |=> (mask_q & $past(cmd.data)) == '0);
    // R4 R5
    mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.op == MOP_NONE |=> $stable(mask_q));
endmodule

// File: rtl/irqbank_cfg.sv
module irqbank_cfg
    import irqbank_pkg::*;
#(
    parameter int NLINES = LINES,
    localparam int IW    = $clog2(NLINES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [IW-1:0]            widx,
    input  word_t                    wdata,
    input  logic [IW-1:0]            ridx,
    output word_t                    rdata,
    output logic [NLINES*WORD_W-1:0] flat
);
    word_t cfg_q [NLINES];

    for (genvar k = 0; k < NLINES; k++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)                             cfg_q[k] <= '0;
            else if (we && widx == IW'(k))       cfg_q[k] <= wdata;
        end
        assign flat[k*WORD_W +: WORD_W] = cfg_q[k];

        // R3
        cfg_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (we && widx == IW'(k)) |=> flat[k*WORD_W +: WORD_W] == $past(wdata));
    end

    assign rdata = cfg_q[ridx];
endmodule

// File: rtl/irqbank_regs.sv
module irqbank_regs
    import irqbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LINES-1:0]        irq_in,
    input  logic [IDX_W-1:0]        bus_idx,
    input  logic                    bus_wr,
    input  logic [WORD_W-1:0]       bus_wdata,
    input  logic                    bus_rd,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic                    wr_err,
    input  logic [WORD_W-1:0]       rsv_status_i,
    input  logic [WORD_W-1:0]       rsv_vaddr_i,
    output logic [LINES*WORD_W-1:0] line_cfg_o,
    output logic [WORD_W-1:0]       enable_o,
    output logic [WORD_W-1:0]       pending_o,
    output logic [WORD_W-1:0]       gcfg_o,
    output logic [WORD_W-1:0]       vbase_o
);
    logic [LINES-1:0] irq_sync;
    word_t            raw_q, ena_w, soft_w, gcfg_q, vbase_q, rdata_q, cfg_rd, pend_w, rd_mux;
    logic             err_q, line_we;
    mask_cmd_t        ena_cmd, soft_cmd;

    irqbank_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(irq_in), .q(irq_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= word_t'(irq_sync);
    end

    assign ena_cmd  = mask_decode(bus_wr, bus_idx, IX_ENA,  IX_ENA_SET,  IX_ENA_CLR,  bus_wdata);
    assign soft_cmd = mask_decode(bus_wr, bus_idx, IX_SOFT, IX_SOFT_SET, IX_SOFT_CLR, bus_wdata);

    irqbank_mask u_ena  (.clk(clk), .rst(rst), .cmd(ena_cmd),  .mask(ena_w));
    irqbank_mask u_soft (.clk(clk), .rst(rst), .cmd(soft_cmd), .mask(soft_w));

    assign line_we = bus_wr && idx_is_line(bus_idx);

    irqbank_cfg #(.NLINES(LINES)) u_cfg (
        .clk(clk), .rst(rst),
        .we(line_we), .widx(bus_idx[LINE_IW-1:0]), .wdata(bus_wdata),
        .ridx(bus_idx[LINE_IW-1:0]), .rdata(cfg_rd),
        .flat(line_cfg_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_q  <= '0;
            vbase_q <= '0;
        end else if (bus_wr) begin
            if (bus_idx == IX_GCFG)  gcfg_q  <= bus_wdata;
            if (bus_idx == IX_VBASE) vbase_q <= bus_wdata;
        end
    end

    assign pend_w = (raw_q | soft_w) & ena_w;

    always_comb begin
        rd_mux = '0;
        if (idx_is_line(bus_idx)) begin
            rd_mux = cfg_rd;
        end else begin
            case (bus_idx)
                IX_ENA:   rd_mux = ena_w;
                IX_PEND:  rd_mux = pend_w;
                IX_RAW:   rd_mux = raw_q;
                IX_SOFT:  rd_mux = soft_w;
                IX_GCFG:  rd_mux = gcfg_q;
                IX_STAT:  rd_mux = rsv_status_i;
                IX_VBASE: rd_mux = vbase_q;
                IX_VADDR: rd_mux = rsv_vaddr_i;
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (bus_rd) rdata_q <= rd_mux;
            err_q <= bus_wr && !idx_writable(bus_idx);
        end
    end

    assign bus_rdata = rdata_q;
    assign wr_err    = err_q;
    assign enable_o  = ena_w;
    assign pending_o = pend_w;
    assign gcfg_o    = gcfg_q;
    assign vbase_o   = vbase_q;

    // R12
    wr_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(bus_wr));
    // R8
    stat_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_idx == IX_STAT) |=> bus_rdata == $past(rsv_status_i));
    // R10
    alias_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_idx == IX_ENA_SET || bus_idx == IX_SOFT_CLR)) |=> bus_rdata == '0);
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
    // R11
    gcfg_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_idx == IX_STAT) |=> $stable(gcfg_o) && $stable(vbase_o));
endmodule

// File: tb/irqbank_regs_tb.sv
module irqbank_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [31:0]  irq_in = '0;
    logic [5:0]   bus_idx = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic         wr_err;
    logic [31:0]  rsv_status_i = '0;
    logic [31:0]  rsv_vaddr_i = '0;
    logic [1023:0] line_cfg_o;
    logic [31:0]  enable_o, pending_o, gcfg_o, vbase_o;

    irqbank_regs dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_idx(bus_idx), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .wr_err(wr_err),
        .rsv_status_i(rsv_status_i), .rsv_vaddr_i(rsv_vaddr_i), .line_cfg_o(line_cfg_o),
        .enable_o(enable_o), .pending_o(pending_o), .gcfg_o(gcfg_o), .vbase_o(vbase_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_cfg [32];
    logic [31:0] m_ena, m_soft, m_gcfg, m_vbase, m_raw;
    logic [31:0] lcg = 32'h1234_5678;

    function automatic logic [31:0] nxt(logic [31:0] x);
        return x * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic writable(int ix);
        return ix < 32 || ix == 32 || ix == 33 || ix == 34 || ix == 37 || ix == 38 ||
               ix == 39 || ix == 40 || ix == 42;
    endfunction

    function automatic string tag_of(int ix);
        if (ix < 32) return "R3";
        case (ix)
            32: return "R4";
            37: return "R5";
            35: return "R7";
            36: return "R6";
            40, 42: return "R9";
            41, 43: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(int ix);
        if (ix < 32) return m_cfg[ix];
        case (ix)
            32: return m_ena;
            35: return (m_raw | m_soft) & m_ena;
            36: return m_raw;
            37: return m_soft;
            40: return m_gcfg;
            41: return rsv_status_i;
            42: return m_vbase;
            43: return rsv_vaddr_i;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 32; k++) m_cfg[k] = '0;
        m_ena = '0; m_soft = '0; m_gcfg = '0; m_vbase = '0; m_raw = '0;
    endtask

    task automatic model_write(int ix, logic [31:0] d);
        if (ix < 32) m_cfg[ix] = d;
        case (ix)
            32: m_ena = d;
            33: m_ena = m_ena | d;
            34: m_ena = m_ena & ~d;
            37: m_soft = d;
            38: m_soft = m_soft | d;
            39: m_soft = m_soft & ~d;
            40: m_gcfg = d;
            42: m_vbase = d;
            default: ;
        endcase
    endtask

    task automatic bus_write(int ix, logic [31:0] d);
        @(negedge clk);
        bus_idx = 6'(ix); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R12: strobe one cycle after the write
        check("R12", 32'(wr_err), 32'(!writable(ix)));
        bus_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R12", 32'(wr_err), 32'h0);
        model_write(ix, d);
    endtask

    task automatic bus_read(int ix, output logic [31:0] d);
        @(negedge clk);
        bus_idx = 6'(ix); bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic sweep_read();
        logic [31:0] v;
        for (int ix = 0; ix < 64; ix++) begin
            bus_read(ix, v);
            check(tag_of(ix), v, exp_read(ix));
        end
    endtask

    task automatic check_outputs(string req);
        check(req, enable_o, m_ena);
        check(req, gcfg_o, m_gcfg);
        check(req, vbase_o, m_vbase);
        check(req, pending_o, (m_raw | m_soft) & m_ena);
        for (int k = 0; k < 32; k++) check(req, line_cfg_o[k*32 +: 32], m_cfg[k]);
    endtask

    bit done = 0;
    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<=150000", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state at ports and through readback
        check_outputs("R1");
        sweep_read();

        // R2 R12: write a distinct pattern to every index of the map
        for (int ix = 0; ix < 64; ix++) begin
            lcg = nxt(lcg);
            bus_write(ix, lcg ^ (32'(ix) << 26));
        end
        // R2 R3 R9 R10 R11: full readback against the model
        rsv_status_i = 32'h8000_0013; rsv_vaddr_i = 32'h0001_0260;
        sweep_read();
        check_outputs("R3");

        // R4 R5: mixed load/set/clear sequence on both masks
        for (int i = 0; i < 60; i++) begin
            int ops [6] = '{32, 33, 34, 37, 38, 39};
            lcg = nxt(lcg);
            bus_write(ops[i % 6], lcg);
            bus_read(32, v); check("R4", v, m_ena);
            bus_read(37, v); check("R5", v, m_soft);
            check("R4", enable_o, m_ena);
        end

        // R6: synchronizer latency, enable all, no software requests
        bus_write(32, 32'hFFFF_FFFF);
        bus_write(37, 32'h0);
        repeat (4) @(posedge clk);
        for (int p = 0; p < 6; p++) begin
            logic [31:0] old_raw;
            old_raw = m_raw;
            lcg = nxt(lcg);
            @(negedge clk); irq_in = lcg;
            @(posedge clk); @(negedge clk);
            @(posedge clk); @(negedge clk);
            check("R6", pending_o, old_raw);
            @(posedge clk); @(negedge clk);
            m_raw = lcg;
            check("R6", pending_o, m_raw);
            bus_read(36, v); check("R6", v, m_raw);
        end

        // R7: pending under hardware-only, software-only and gated patterns
        @(negedge clk); irq_in = 32'h0000_FF00;
        repeat (4) @(posedge clk);
        m_raw = 32'h0000_FF00;
        bus_write(32, 32'h0F0F_0F0F);
        bus_write(37, 32'h00F0_0003);
        bus_read(35, v); check("R7", v, 32'h0000_0F03);
        check("R7", pending_o, 32'h0000_0F03);
        bus_write(34, 32'hFFFF_FFFF);
        check("R7", pending_o, 32'h0);
        bus_write(32, 32'hFFFF_FFFF);
        bus_write(37, 32'h0);
        check("R7", pending_o, 32'h0000_FF00);

        // R11: writes to read-only indices leave everything unchanged
        bus_write(35, 32'hFFFF_FFFF);
        bus_write(36, 32'hFFFF_FFFF);
        bus_write(41, 32'hFFFF_FFFF);
        bus_write(43, 32'hFFFF_FFFF);
        for (int ix = 32; ix < 44; ix++) begin
            bus_read(ix, v);
            check("R11", v, exp_read(ix));
        end
        check_outputs("R11");

        // R8: resolver inputs read as driven
        rsv_status_i = 32'hDEAD_0001; rsv_vaddr_i = 32'h0000_4440;
        bus_read(41, v); check("R8", v, 32'hDEAD_0001);
        bus_read(43, v); check("R8", v, 32'h0000_4440);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1; irq_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model_reset();
        rsv_status_i = '0; rsv_vaddr_i = '0;
        check_outputs("R1");
        sweep_read();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule